// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block assembles an 8-bit status byte from live summary conditions supplied by neighbouring status structures, and holds an 8-bit service request enable mask that a host writes and reads back. Bit 6 of the status byte is not a condition. It is a master summary: the OR of every other status bit whose enable bit is set. A rising edge of that summary latches a request-for-service flag, and the flag drives the service request output.

There are two read views of the byte. The plain status view shows the live summary in bit 6 and is never disturbed by being read. The serial-poll view shows the latched request flag in bit 6. Asserting the poll strobe for one cycle clears the flag at the next clock edge. Once a poll clears the flag, it stays clear while the summary remains high. It sets again only after the summary falls and rises once more.

Top module: `svc_req_status`

## Requirements
- R1: A write (en_wr_i high at a clock edge) stores en_wdata_i into the enable mask with bit 6 forced to 0. en_rdata_o shows the stored mask from the following cycle. Without a write the mask holds its value.
- R2: stb_o bits 7 and 0 to 5 equal cond_i bits 7 and 0 to 5 in the same cycle. The assignments are: bit 7 operation summary, bit 5 event status summary, bit 4 message available, bit 3 questionable summary, bit 2 error queue not empty, bit 1 list running, bit 0 busy. cond_i[6] has no effect on any output.
- R3: stb_o[6] is the OR of (cond_i & mask) over bits 0 to 5 and 7, in the same cycle.
- R4: A serial poll leaves stb_o unchanged, both in the cycle of the poll and afterwards.
- R5: poll_data_o equals stb_o with bit 6 replaced by the request flag. A poll_i pulse clears the flag at that clock edge. The exception is when the summary rises at that same edge, in which case the flag stays set.
- R6: The request flag sets at the clock edge where the summary is 1 and was 0 in the previous cycle. Without a poll it stays set. srq_o equals the flag.
- R7: After a poll clears the flag, it does not set again while the summary stays high.
- R8: Reset clears the enable mask, the request flag and the stored previous summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | 8 | Live summary conditions (bit 6 unused) |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 8 | Enable mask write data |
| en_rdata_o | output | 8 | Enable mask read-back |
| stb_o | output | 8 | Status byte, bit 6 = live summary |
| poll_i | input | 1 | Serial-poll strobe, clears the request flag |
| poll_data_o | output | 8 | Serial-poll byte, bit 6 = request flag |
| srq_o | output | 1 | Service request output |

## Verification
stb_o and poll_data_o are combinational, so they are due in the same cycle as cond_i and the current mask. The mask read-back and the request flag are due one clock edge after the write, rise or poll that changes them. The bench drives inputs on the falling edge and compares shortly afterwards, against a model state that it advances only at the rising edge. This way each output is checked in the cycle it is due. A sweep over all 256 mask values, crossed with one-hot and extreme condition patterns and periodic polls, covers the summary and the masking. Directed sequences cover a poll while the summary is held high and a poll at the same edge as a rise.

// File: rtl/srq_pkg.sv
`timescale 1ns/1ps
package srq_pkg;
  localparam int unsigned STB_W   = 8;
  localparam int unsigned SUM_POS = 6;
endpackage

// File: rtl/srq_enable_reg.sv
`timescale 1ns/1ps
module srq_enable_reg #(
  parameter int unsigned W    = srq_pkg::STB_W,
  parameter int unsigned HOLE = srq_pkg::SUM_POS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o
);
  localparam logic [W-1:0] HOLE_MASK = ~(W'(1) << HOLE);

  logic [W-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= wdata_i & HOLE_MASK;
  end

  assign en_o = en_q;

  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_o == ($past(wdata_i) & HOLE_MASK)));  // R1
  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));  // R1
endmodule

// File: rtl/srq_summary.sv
`timescale 1ns/1ps
module srq_summary #(
  parameter int unsigned W    = srq_pkg::STB_W,
  parameter int unsigned HOLE = srq_pkg::SUM_POS
) (
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] stb_o,
  output logic         mss_o
);
  localparam logic [W-1:0] HOLE_MASK = ~(W'(1) << HOLE);

  assign mss_o = |(cond_i & en_i & HOLE_MASK);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == HOLE) begin : g_sum
      assign stb_o[i] = mss_o;
    end else begin : g_cond
      assign stb_o[i] = cond_i[i];
    end
  end
endmodule

// File: rtl/srq_flag.sv
`timescale 1ns/1ps
module srq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mss_i,
  input  logic poll_i,
  output logic rqs_o
);
  logic mss_q, rqs_q, rise;

  assign rise = mss_i & ~mss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mss_q <= 1'b0;
      rqs_q <= 1'b0;
    end else begin
      mss_q <= mss_i;
      // a new rise outranks a same-cycle poll so no request is lost
      if (rise)        rqs_q <= 1'b1;
      else if (poll_i) rqs_q <= 1'b0;
    end
  end

  assign rqs_o = rqs_q;

  AST_RQS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mss_i && !mss_q) |=> rqs_o);  // R6
  AST_RQS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rqs_o && !poll_i) |=> rqs_o);  // R6
  AST_POLL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_i && !(mss_i && !mss_q)) |=> !rqs_o);  // R5
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rqs_o && mss_q && mss_i) |=> !rqs_o);  // R7
endmodule

// File: rtl/svc_req_status.sv
`timescale 1ns/1ps
module svc_req_status #(
  parameter int unsigned W    = srq_pkg::STB_W,
  parameter int unsigned HOLE = srq_pkg::SUM_POS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cond_i,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_wdata_i,
  output logic [W-1:0] en_rdata_o,
  output logic [W-1:0] stb_o,
  input  logic         poll_i,
  output logic [W-1:0] poll_data_o,
  output logic         srq_o
);
  localparam logic [W-1:0] HOLE_BIT = W'(1) << HOLE;

  logic [W-1:0] en;
  logic         mss, rqs;

  srq_enable_reg #(.W(W), .HOLE(HOLE)) u_en (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(en_wr_i), .wdata_i(en_wdata_i), .en_o(en)
  );

  srq_summary #(.W(W), .HOLE(HOLE)) u_sum (
    .cond_i(cond_i), .en_i(en), .stb_o(stb_o), .mss_o(mss)
  );

  srq_flag u_flag (
    .clk_i(clk_i), .rst_ni(rst_ni), .mss_i(mss), .poll_i(poll_i), .rqs_o(rqs)
  );

  assign en_rdata_o  = en;
  assign poll_data_o = (stb_o & ~HOLE_BIT) | (rqs ? HOLE_BIT : '0);
  assign srq_o       = rqs;

  AST_EN_HOLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr_i |=> !en_rdata_o[HOLE]);  // R1
endmodule

// File: tb/svc_req_status_tb_top.sv
`timescale 1ns/1ps
module svc_req_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cond = '0;
  logic       en_wr = 1'b0;
  logic [7:0] en_wdata = '0;
  logic       poll = 1'b0;
  logic [7:0] en_rdata, stb, poll_data;
  logic       srq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] m_en;
  logic       m_rqs, m_prev;

  always #5 clk = ~clk;

  svc_req_status dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .en_wr_i(en_wr),
    .en_wdata_i(en_wdata), .en_rdata_o(en_rdata), .stb_o(stb),
    .poll_i(poll), .poll_data_o(poll_data), .srq_o(srq)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic model_mss(logic [7:0] c);
    return |(c & m_en & 8'hBF);
  endfunction

  function automatic logic [7:0] model_stb(logic [7:0] c);
    return (c & 8'hBF) | (model_mss(c) ? 8'h40 : 8'h00);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en_wr = 1'b0; poll = 1'b0;
    m_en = '0; m_rqs = 1'b0; m_prev = 1'b0;
    #1;
    check("R8 mask", en_rdata, 8'h00);
    check("R8 srq", {7'b0, srq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive at negedge, compare, advance model at posedge
  task automatic step(logic [7:0] c, logic wr, logic [7:0] wd, logic p);
    logic m, rise;
    @(negedge clk);
    cond = c; en_wr = wr; en_wdata = wd; poll = p;
    #1;
    check("R1", en_rdata, m_en);
    check(p ? "R4" : "R3", stb, model_stb(c));
    check("R5", poll_data, (model_stb(c) & 8'hBF) | (m_rqs ? 8'h40 : 8'h00));
    check("R6", {7'b0, srq}, {7'b0, m_rqs});
    m = model_mss(c);
    rise = m & ~m_prev;
    @(posedge clk);
    if (rise)   m_rqs = 1'b1;
    else if (p) m_rqs = 1'b0;
    m_prev = m;
    if (wr) m_en = wd & 8'hBF;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual running expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 R2 R3 R4 sweep: every mask value, one-hot and extreme conditions
    for (int e = 0; e < 256; e++) begin
      step(8'h00, 1'b1, 8'(e), 1'b0);
      for (int k = 0; k < 10; k++) begin
        logic [7:0] c;
        c = (k < 8) ? (8'h01 << k) : ((k == 8) ? 8'h00 : 8'hFF);
        step(c, 1'b0, 8'h00, (k % 3) == 2);
      end
    end
    // R2: cond bit 6 alone is ignored, even with every mask bit requested
    step(8'h00, 1'b1, 8'hFF, 1'b1);
    check("R1 hole", en_rdata, 8'hBF);
    step(8'h40, 1'b0, 8'h00, 1'b0);
    step(8'h40, 1'b0, 8'h00, 1'b0);
    check("R2", {7'b0, srq}, 8'h00);
    // R6 R7: rise, hold, poll while held, no re-arm, fall and rise again
    step(8'h00, 1'b1, 8'h10, 1'b0);
    step(8'h10, 1'b0, 8'h00, 1'b0);
    step(8'h10, 1'b0, 8'h00, 1'b0);
    check("R6", {7'b0, srq}, 8'h01);
    step(8'h10, 1'b0, 8'h00, 1'b1);
    for (int i = 0; i < 4; i++) step(8'h10, 1'b0, 8'h00, 1'b0);
    check("R7", {7'b0, srq}, 8'h00);
    step(8'h00, 1'b0, 8'h00, 1'b0);
    step(8'h10, 1'b0, 8'h00, 1'b0);
    step(8'h10, 1'b0, 8'h00, 1'b0);
    check("R6 rearm", {7'b0, srq}, 8'h01);
    // R5: poll at the same edge as a fresh rise keeps the flag
    step(8'h00, 1'b0, 8'h00, 1'b1);
    step(8'h10, 1'b0, 8'h00, 1'b1);
    step(8'h10, 1'b0, 8'h00, 1'b0);
    check("R5 rise wins", {7'b0, srq}, 8'h01);
    // R8: reset mid-run
    do_reset();
    step(8'hFF, 1'b0, 8'h00, 1'b0);
    step(8'hFF, 1'b0, 8'h00, 1'b0);
    check("R8 after", {7'b0, srq}, 8'h00);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule